// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits beside a receive MAC. It watches the received byte stream and decides whether each Ethernet frame is kept. The first six bytes of a frame form the destination address (DA). The block classifies that address as individual, multicast or broadcast and checks it against a set of address-filter enables. The result of that filter is available on a port as soon as the sixth byte has been taken in.

While the frame streams in, the block counts its length. At the end of the frame it sorts the frame into exactly one quality class, using the length and the CRC-valid flag supplied by the MAC. A frame is accepted only if it passes the address filter and its quality class is enabled. In parallel the block drives a write enable for the receive buffer, and that enable stops once the maximum buffered length has been written.

The hash calculation, CRC checking and the buffer memory all lie outside this block. The hash result arrives on `hash_pass`, and the CRC verdict arrives on `crc_ok` with the last byte.

Top module: `rx_accept_filter`

## Requirements
- R1: A byte counts only when `rx_valid` is high and it either carries `rx_sof` or falls inside a frame. A frame opens with an `rx_sof` byte and closes with an `rx_eof` byte, and the same byte may carry both. A valid byte outside a frame raises neither `buf_we` nor `res_valid`.
- R2: `da_done` rises in the cycle after the sixth frame byte and holds until the next `rx_sof`. Received byte i (0 first) is compared with `ind_addr[8i+7:8i]`. `da_kind` is 2 when all 48 DA bits are ones, 1 when bit 0 of byte 0 is 1 and the DA is not broadcast, and 0 otherwise.
- R3: `da_pass`, registered with `da_done`, is 1 when any of the following holds, with bit positions taken from `rx_ctl`:
  - bit 10 is set and the DA equals `ind_addr`;
  - bit 11 is set and the DA is broadcast;
  - bit 9 is set, the DA is multicast and `hash_pass` is 1 at the sixth byte;
  - bit 6 is set, the DA is individual and `hash_pass` is 1;
  - bit 7 (promiscuous) is set.
- R4: `res_class` is 2 (runt) when the length is below 64 bytes. Otherwise it is 3 (oversized) when the length is above 1518. Otherwise it is 1 when `crc_ok` is 0 at the last byte, and 0 (good) in the remaining case.
- R5: `res_accept` is the address-filter pass ANDed with the enable bit of the frame's class: bit 8 for good, 12 for bad CRC, 13 for runt and 14 for oversized.
- R6: A frame of fewer than six bytes is always rejected, and it leaves `da_done` low.
- R7: `res_valid` is high for exactly one cycle, the cycle after the `rx_eof` byte, with `res_accept` and `res_class` valid alongside it.
- R8: `buf_we` is high for each of the first 1518 bytes of a frame and low for every later byte of that frame. This holds whatever the accept decision turns out to be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_byte | input | 8 | Received byte |
| crc_ok | input | 1 | CRC verdict, sampled with the last byte |
| hash_pass | input | 1 | External hash-filter result, sampled with the sixth byte |
| ind_addr | input | 48 | Programmed individual address, byte 0 in bits 7:0 |
| rx_ctl | input | 16 | Receive acceptance control |
| buf_we | output | 1 | Buffer write enable for the current byte |
| da_done | output | 1 | Destination address complete |
| da_pass | output | 1 | Address-filter result |
| da_kind | output | 2 | 0 individual, 1 multicast, 2 broadcast |
| res_valid | output | 1 | One-cycle decision strobe |
| res_accept | output | 1 | Frame accepted |
| res_class | output | 2 | 0 good, 1 bad CRC, 2 runt, 3 oversized |

## Verification
The bench targets the length edges at 63/64 and 1518/1519 bytes, where an off-by-one comparison would put the frame in the wrong class and flip the decision. It also drives frames of one, five and six bytes, where an incomplete address could be passed, especially when the promiscuous bit is set. A sweep over every combination of address enable, address kind and hash flag exposes a multicast rule that lets broadcast through the hash path, or a hash-individual rule that fires on group addresses. Byte counts of `buf_we` on frames of 1519 and 1530 bytes catch a write enable that runs one byte past the limit or never stops.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      CLS_GOOD   = 2'd0,
      CLS_BADCRC = 2'd1,
      CLS_RUNT   = 2'd2,
      CLS_OVER   = 2'd3
   } frame_class_e;

   typedef enum logic [1:0] {
      KIND_IND   = 2'd0,
      KIND_MCAST = 2'd1,
      KIND_BCAST = 2'd2
   } da_kind_e;

   // control bit positions: a neighbour register decodes these
   localparam int BIT_HASH_IND = 6;
   localparam int BIT_PROMISC  = 7;
   localparam int BIT_GOOD     = 8;
   localparam int BIT_MCAST    = 9;
   localparam int BIT_IND      = 10;
   localparam int BIT_BCAST    = 11;
   localparam int BIT_BADCRC   = 12;
   localparam int BIT_RUNT     = 13;
   localparam int BIT_OVER     = 14;

   typedef struct packed {
      logic hash_ind;
      logic promisc;
      logic mcast;
      logic ind;
      logic bcast;
   } addr_en_t;

   typedef struct packed {
      logic good;
      logic badcrc;
      logic runt;
      logic over;
   } qual_en_t;

endpackage

// File: rtl/rxf_len_counter.sv
module rxf_len_counter
   import rxf_pkg::*;
#(
   parameter int MIN_LEN = 64,
   parameter int MAX_LEN = 1518,
   parameter int IW      = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic          rx_sof,
   input  logic          rx_eof,
   output logic          in_byte,
   output logic          frame_end,
   output logic          buf_we,
   output logic          is_runt,
   output logic          is_over,
   output logic [IW-1:0] byte_idx
);

   localparam logic [IW-1:0] SAT_VAL  = IW'(MAX_LEN + 1);
   localparam logic [IW-1:0] WE_LIM   = IW'(MAX_LEN);
   localparam logic [IW-1:0] RUNT_LIM = IW'(MIN_LEN - 1);

   logic          in_frame_q;
   logic [IW-1:0] cnt_q;
   logic [IW-1:0] cnt_d;

   assign in_byte   = rx_valid & (rx_sof | in_frame_q);
   assign byte_idx  = rx_sof ? '0 : cnt_q;
   assign frame_end = in_byte & rx_eof;
   assign buf_we    = in_byte & (byte_idx < WE_LIM);

   // length of the frame ending now is byte_idx + 1
   assign is_runt = (byte_idx < RUNT_LIM);
   assign is_over = (byte_idx >= WE_LIM);

   always_comb begin
      if (byte_idx < SAT_VAL) cnt_d = byte_idx + IW'(1);
      else                    cnt_d = byte_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         cnt_q      <= '0;
      end else if (in_byte) begin
         in_frame_q <= ~rx_eof;
         cnt_q      <= cnt_d;
      end
   end

   // R8: once the write limit is hit inside a frame, no more writes until a new frame
   a_r8_we_stays_off : assert property (@(posedge clk) disable iff (!rst_n)
      (in_byte && !buf_we && !rx_eof) |=> (!buf_we || rx_sof));

   // R1: a write needs a byte strobe
   a_r1_we_needs_byte : assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> rx_valid);

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
   import rxf_pkg::*;
(
   input  addr_en_t en,
   input  da_kind_e kind,
   input  logic     ia_match,
   input  logic     hash_pass,
   output logic     pass
);

   logic hit_ind;
   logic hit_bcast;
   logic hit_mcast;
   logic hit_hind;

   always_comb begin
      hit_ind   = en.ind   & ia_match;
      hit_bcast = en.bcast & (kind == KIND_BCAST);
      hit_mcast = en.mcast & (kind == KIND_MCAST) & hash_pass;
      hit_hind  = en.hash_ind & (kind == KIND_IND) & hash_pass;
      pass      = hit_ind | hit_bcast | hit_mcast | hit_hind | en.promisc;
   end

endmodule

// File: rtl/rxf_da_capture.sv
module rxf_da_capture
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int IW         = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_byte,
   input  logic                    rx_sof,
   input  logic [IW-1:0]           byte_idx,
   input  logic [7:0]              rx_byte,
   input  logic [8*ADDR_BYTES-1:0] ind_addr,
   input  logic                    hash_pass,
   input  addr_en_t                en,
   output logic                    da_done,
   output logic                    da_pass,
   output da_kind_e                da_kind,
   output logic                    pass_eff
);

   localparam int LAST = ADDR_BYTES - 1;

   logic [7:0]              byte_q [LAST];
   logic [8*ADDR_BYTES-1:0] da_w;
   logic                    last_now;
   logic                    bcast_w;
   logic                    ia_match_w;
   logic                    pass_w;
   da_kind_e                kind_w;

   assign last_now = in_byte & (byte_idx == IW'(LAST));

   for (genvar g = 0; g < LAST; g++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    byte_q[g] <= '0;
         else if (in_byte && (byte_idx == IW'(g)))      byte_q[g] <= rx_byte;
      end
      assign da_w[8*g +: 8] = byte_q[g];
   end
   assign da_w[8*LAST +: 8] = rx_byte;

   always_comb begin
      bcast_w    = &da_w;
      ia_match_w = (da_w == ind_addr);
      if (bcast_w)       kind_w = KIND_BCAST;
      else if (da_w[0])  kind_w = KIND_MCAST;
      else               kind_w = KIND_IND;
   end

   rxf_addr_filter u_filt (
      .en        (en),
      .kind      (kind_w),
      .ia_match  (ia_match_w),
      .hash_pass (hash_pass),
      .pass      (pass_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         da_done <= 1'b0;
         da_pass <= 1'b0;
         da_kind <= KIND_IND;
      end else if (last_now) begin
         da_done <= 1'b1;
         da_pass <= pass_w;
         da_kind <= kind_w;
      end else if (in_byte && rx_sof) begin
         da_done <= 1'b0;
         da_pass <= 1'b0;
         da_kind <= KIND_IND;
      end
   end

   // filter result as seen by a frame ending on the current byte
   always_comb begin
      if (last_now)                pass_eff = pass_w;
      else if (da_done && !rx_sof) pass_eff = da_pass;
      else                         pass_eff = 1'b0;
   end

   // R2: done rises only after a frame byte was taken
   a_r2_done_after_byte : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(da_done) |-> $past(in_byte));

   // R2: kind is never the unused code
   a_r2_kind_legal : assert property (@(posedge clk) disable iff (!rst_n)
      da_done |-> (da_kind != da_kind_e'(2'd3)));

   // R3: a pass without done is impossible
   a_r3_pass_needs_done : assert property (@(posedge clk) disable iff (!rst_n)
      da_pass |-> da_done);

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int MIN_LEN    = 64,
   parameter int MAX_LEN    = 1518,
   parameter int CTL_W      = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_valid,
   input  logic                    rx_sof,
   input  logic                    rx_eof,
   input  logic [7:0]              rx_byte,
   input  logic                    crc_ok,
   input  logic                    hash_pass,
   input  logic [8*ADDR_BYTES-1:0] ind_addr,
   input  logic [CTL_W-1:0]        rx_ctl,
   output logic                    buf_we,
   output logic                    da_done,
   output logic                    da_pass,
   output logic [1:0]              da_kind,
   output logic                    res_valid,
   output logic                    res_accept,
   output logic [1:0]              res_class
);

   localparam int IW = $clog2(MAX_LEN + 2);

   if (ADDR_BYTES < 2) begin : g_chk_addr
      $error("ADDR_BYTES must be at least 2");
   end
   if (MIN_LEN <= ADDR_BYTES || MIN_LEN >= MAX_LEN) begin : g_chk_len
      $error("length limits out of order");
   end
   if (CTL_W <= BIT_OVER) begin : g_chk_ctl
      $error("control word too narrow");
   end

   logic          in_byte;
   logic          frame_end;
   logic          is_runt;
   logic          is_over;
   logic          pass_eff;
   logic [IW-1:0] byte_idx;
   addr_en_t      aen;
   qual_en_t      qen;
   da_kind_e      kind_q;
   frame_class_e  cls_w;
   logic          cls_en;

   assign aen.hash_ind = rx_ctl[BIT_HASH_IND];
   assign aen.promisc  = rx_ctl[BIT_PROMISC];
   assign aen.mcast    = rx_ctl[BIT_MCAST];
   assign aen.ind      = rx_ctl[BIT_IND];
   assign aen.bcast    = rx_ctl[BIT_BCAST];
   assign qen.good     = rx_ctl[BIT_GOOD];
   assign qen.badcrc   = rx_ctl[BIT_BADCRC];
   assign qen.runt     = rx_ctl[BIT_RUNT];
   assign qen.over     = rx_ctl[BIT_OVER];

   rxf_len_counter #(
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN),
      .IW      (IW)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_sof    (rx_sof),
      .rx_eof    (rx_eof),
      .in_byte   (in_byte),
      .frame_end (frame_end),
      .buf_we    (buf_we),
      .is_runt   (is_runt),
      .is_over   (is_over),
      .byte_idx  (byte_idx)
   );

   rxf_da_capture #(
      .ADDR_BYTES (ADDR_BYTES),
      .IW         (IW)
   ) u_da (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_byte   (in_byte),
      .rx_sof    (rx_sof),
      .byte_idx  (byte_idx),
      .rx_byte   (rx_byte),
      .ind_addr  (ind_addr),
      .hash_pass (hash_pass),
      .en        (aen),
      .da_done   (da_done),
      .da_pass   (da_pass),
      .da_kind   (kind_q),
      .pass_eff  (pass_eff)
   );

   assign da_kind = kind_q;

   // priority: runt, oversized, bad CRC, good
   always_comb begin
      if (is_runt)      cls_w = CLS_RUNT;
      else if (is_over) cls_w = CLS_OVER;
      else if (!crc_ok) cls_w = CLS_BADCRC;
      else              cls_w = CLS_GOOD;
      unique case (cls_w)
         CLS_RUNT:   cls_en = qen.runt;
         CLS_OVER:   cls_en = qen.over;
         CLS_BADCRC: cls_en = qen.badcrc;
         default:    cls_en = qen.good;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_class  <= CLS_GOOD;
      end else begin
         res_valid <= frame_end;
         if (frame_end) begin
            res_accept <= pass_eff & cls_en;
            res_class  <= cls_w;
         end
      end
   end

   // R7: a decision strobe always follows a closing byte
   a_r7_result_after_eof : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(rx_valid && rx_eof));

   // R5: acceptance implies the address filter passed
   a_r5_accept_needs_filter : assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_accept) |-> da_pass);

   // R6: an accepted frame has a complete address
   a_r6_accept_needs_da : assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_accept) |-> da_done);

endmodule

// File: tb/sim_rx_accept_filter.sv
module sim_rx_accept_filter;
   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] IA = 48'h5544_3322_1100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        crc_ok = 1'b0, hash_pass = 1'b0;
   logic [47:0] ind_addr = IA;
   logic [15:0] rx_ctl = '0;
   logic        buf_we, da_done, da_pass, res_valid, res_accept;
   logic [1:0]  da_kind, res_class;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_accept_filter u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_byte(rx_byte), .crc_ok(crc_ok), .hash_pass(hash_pass),
      .ind_addr(ind_addr), .rx_ctl(rx_ctl), .buf_we(buf_we), .da_done(da_done),
      .da_pass(da_pass), .da_kind(da_kind), .res_valid(res_valid),
      .res_accept(res_accept), .res_class(res_class)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_kind(input logic [47:0] da);
      if (&da) return 2;
      if (da[0]) return 1;
      return 0;
   endfunction

   function automatic bit exp_pass(input logic [47:0] da, input bit h, input logic [15:0] c);
      int k = exp_kind(da);
      return (c[10] && da == IA) || (c[11] && k == 2) || (c[9] && k == 1 && h)
          || (c[6] && k == 0 && h) || c[7];
   endfunction

   function automatic int exp_class(input int len, input bit crc);
      if (len < 64) return 2;
      if (len > 1518) return 3;
      if (!crc) return 1;
      return 0;
   endfunction

   task automatic send_frame(input logic [47:0] da, input int len, input bit crc, input bit h);
      int wes = 0;
      int cls, ewe;
      bit pass, acc;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof = (i == 0);
         rx_eof = (i == len - 1);
         rx_byte = (i < 6) ? da[8*i +: 8] : 8'(i);
         crc_ok = crc;
         hash_pass = h;
         #1;
         if (buf_we) wes++;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      #1;
      cls = exp_class(len, crc);
      pass = (len >= 6) && exp_pass(da, h, rx_ctl);
      case (cls)
         0: acc = pass && rx_ctl[8];
         1: acc = pass && rx_ctl[12];
         2: acc = pass && rx_ctl[13];
         default: acc = pass && rx_ctl[14];
      endcase
      ewe = (len < 1518) ? len : 1518;
      chk(res_valid === 1'b1, "R7 res_valid after eof", int'(res_valid), 1);
      chk(int'(res_class) == cls, "R4 class", int'(res_class), cls);
      chk(res_accept === acc, "R5 accept", int'(res_accept), int'(acc));
      chk(wes == ewe, "R8 buf_we count", wes, ewe);
      chk(da_done === (len >= 6), "R6 da_done", int'(da_done), int'(len >= 6));
      if (len >= 6) begin
         chk(da_pass === pass, "R3 da_pass", int'(da_pass), int'(pass));
         chk(int'(da_kind) == exp_kind(da), "R2 da_kind", int'(da_kind), exp_kind(da));
      end
      @(negedge clk);
      #1;
      chk(res_valid === 1'b0, "R7 strobe one cycle", int'(res_valid), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [47:0] das [4];
      int lens [10] = '{1, 5, 6, 7, 63, 64, 65, 1518, 1519, 1530};
      logic [15:0] quals [5] = '{16'h0100, 16'h1000, 16'h2000, 16'h4000, 16'h7100};
      int abits [5] = '{6, 7, 9, 10, 11};
      das[0] = IA;
      das[1] = IA ^ 48'h0100_0000_0000;
      das[2] = IA | 48'h1;
      das[3] = '1;

      repeat (3) @(negedge clk);
      #1;
      chk(res_valid === 1'b0, "R7 reset res_valid", int'(res_valid), 0);
      chk(da_done === 1'b0, "R2 reset da_done", int'(da_done), 0);
      chk(buf_we === 1'b0, "R8 reset buf_we", int'(buf_we), 0);
      rst_n = 1'b1;

      // address filter sweep on good 64-byte frames
      for (int m = 0; m < 32; m++) begin
         for (int d = 0; d < 4; d++) begin
            for (int h = 0; h < 2; h++) begin
               rx_ctl = 16'h7100;
               for (int b = 0; b < 5; b++) if (m[b]) rx_ctl[abits[b]] = 1'b1;
               send_frame(das[d], 64, 1'b1, h[0]);
            end
         end
      end

      // quality classes and length edges, promiscuous
      for (int q = 0; q < 5; q++) begin
         for (int l = 0; l < 10; l++) begin
            for (int c = 0; c < 2; c++) begin
               rx_ctl = quals[q] | 16'h0080;
               send_frame(das[1], lens[l], c[0], 1'b0);
            end
         end
      end

      // R1: valid bytes outside any frame are ignored
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 2); rx_byte = 8'hA5;
         #1;
         chk(buf_we === 1'b0, "R1 stray byte no write", int'(buf_we), 0);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
      #1;
      chk(res_valid === 1'b0, "R1 stray eof no result", int'(res_valid), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule